// File: doc/BRIEF.md
# DDR Command Spacing and Bank State Guard

This block watches the command bus between a memory controller and a DDR SDRAM device. Every clock it decodes the chip-select, row strobe, column strobe, write enable, the two bank-address bits and address bit 10 into one command. It keeps an open/idle flag for each of the four banks and a set of down-counters that enforce the minimum cycle spacing the device requires between commands. These are: write or read to precharge of the same bank, write to read, read to write, burst stop to write, and mode-register load to activate or to another mode-register load.

For the command on the bus, the guard answers in the same cycle. `stall` means the command is legal in kind but too early, so the issuer must hold it and present it again. `viol` means the command contradicts the bank state: an activate to an open bank, or a column access to an idle bank. A command that raises either flag is dropped and changes no state. CAS latency (2 or 2.5) and burst length (2, 4 or 8) are static configuration inputs. They are sampled when each command is accepted, and they set the spacing counters loaded by that command. Refresh commands pass through without checks.

Top module: `ddr_cmd_guard`

## Requirements
- R1: After reset every bank reads idle (`bank_open` = 0000) and every spacing window has expired, so the first command is never stalled.
- R2: The bank index is 2*BA0 + BA1, where `ba[0]` is BA0 and `ba[1]` is BA1. An accepted activate sets `bank_open[index]` from the next cycle on.
- R3: An activate (cs_n=0, ras_n=0, cas_n=1, we_n=1) to an idle bank opens it. An activate to an open bank raises `viol` in that cycle and changes nothing.
- R4: A precharge (ras_n=0, cas_n=1, we_n=0) with A10=1 closes all banks. With A10=0 it closes only the addressed bank and leaves the others as they were.
- R5: A read (ras_n=1, cas_n=0, we_n=1) or a write (ras_n=1, cas_n=0, we_n=0) to an idle bank raises `viol` and loads no spacing counter.
- R6: While cs_n=1 the command inputs are ignored. `stall` and `viol` stay low, the bank state does not change, and the running spacing windows keep counting down.
- R7: A precharge to a bank is stalled until 3+BL/2 cycles after the last write to that bank and BL/2 cycles after the last read to it. A precharge with A10=1 waits for every bank.
- R8: A read is stalled until 2+BL/2 cycles after the last accepted write.
- R9: A write is stalled until 2+BL/2 cycles (CAS latency 2) or 3+BL/2 cycles (CAS latency 2.5) after the last accepted read.
- R10: A burst stop (ras_n=1, cas_n=1, we_n=0) makes writes wait 2 cycles (CAS latency 2) or 3 cycles (2.5) after it. This window replaces any pending read-to-write window.
- R11: A mode-register load (ras_n=cas_n=we_n=0) stalls an activate or another mode-register load for 2 cycles.
- R12: A read or write with A10=1 closes its bank by itself. `bank_open` drops in the cycle in which that bank's precharge window expires, N cycles after the command (N as in R7).
- R13: `stall` and `viol` are combinational and belong to the current command. `stall` has priority over `viol`, and a stalled command changes no state. Encodings: `cfg_bl` 0 = BL2, 1 = BL4, 2 or 3 = BL8; `cfg_cl25` 1 = CAS latency 2.5, 0 = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, low selects |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable |
| ba | input | 2 | Bank address, bit 0 is BA0, bit 1 is BA1 |
| a10 | input | 1 | All-banks / auto-precharge bit |
| cfg_bl | input | 2 | Burst length code |
| cfg_cl25 | input | 1 | CAS latency 2.5 when high |
| stall | output | 1 | Current command is too early |
| viol | output | 1 | Current command contradicts bank state |
| bank_open | output | 4 | Open flag per bank |

## Verification
`stall` and `viol` answer the command present in the same cycle. `bank_open` changes one cycle after an accepted activate or precharge. After an auto-precharging access, `bank_open` drops exactly N cycles after the command. The bench drives each command on the falling edge and samples all outputs 2 ns later, before the next rising edge. Every expected value is therefore an account of how many rising edges have passed since the command that opened a window. Each window is probed on the last stalled cycle and again on the first legal cycle.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_BST,
        CMD_MRS,
        CMD_REF
    } cmd_e;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b110:  c = CMD_BST;
                3'b000:  c = CMD_MRS;
                3'b001:  c = CMD_REF;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         replace_i,
    input  logic [W-1:0] val_i,
    output logic         busy_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] dec;

    always_comb begin
        dec  = (st_q.cnt == '0) ? '0 : st_q.cnt - W'(1);
        st_d = st_q;
        st_d.cnt = dec;
        // a new window either overrides the pending one or extends it
        if (load_i && (replace_i || val_i > dec)) begin
            st_d.cnt = val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         act_i,
    input  logic         close_i,
    input  logic         col_i,
    input  logic         col_ap_i,
    input  logic [W-1:0] col_val_i,
    output logic         open_o,
    output logic         busy_o
);
    typedef struct packed {
        logic         open;
        logic         ap;
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] dec;
    logic expire;

    // auto-precharge completes once the precharge window has run out
    assign expire = st_q.ap && (st_q.cnt == '0);
    assign open_o = st_q.open && !expire;
    assign busy_o = (st_q.cnt != '0);

    always_comb begin
        dec  = (st_q.cnt == '0) ? '0 : st_q.cnt - W'(1);
        st_d = st_q;
        st_d.cnt  = dec;
        st_d.open = open_o;
        st_d.ap   = st_q.ap && !expire;
        if (act_i) begin
            st_d.open = 1'b1;
            st_d.ap   = 1'b0;
        end
        if (col_i) begin
            st_d.ap = col_ap_i;
            if (col_val_i > dec) st_d.cnt = col_val_i;
        end
        if (close_i) begin
            st_d.open = 1'b0;
            st_d.ap   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard #(
    parameter int BL_MAX  = 8,
    parameter int MRD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    input  logic [1:0] cfg_bl,
    input  logic       cfg_cl25,
    output logic       stall,
    output logic       viol,
    output logic [3:0] bank_open
);
    import ddr_guard_pkg::*;

    localparam int NB     = 4;
    localparam int SPAN   = (BL_MAX / 2 + 4 > MRD_CYC) ? BL_MAX / 2 + 4 : MRD_CYC;
    localparam int CNT_W  = $clog2(SPAN + 1);

    cmd_e             cmd;
    logic [1:0]       bidx;
    logic [CNT_W-1:0] bl_half;
    logic [CNT_W-1:0] ld_wr2pre, ld_rd2pre, ld_wr2rd, ld_rd2wr, ld_bst2wr, ld_mrd;
    logic [NB-1:0]    slot_open, slot_busy;
    logic             rdgate_busy, wrgate_busy, mrs_busy;
    logic             sel_open, accept;
    logic             wrgate_load, wrgate_replace;
    logic [CNT_W-1:0] wrgate_val;

    assign cmd      = decode_cmd(cs_n, ras_n, cas_n, we_n);
    assign bidx     = {ba[0], ba[1]};
    assign sel_open = slot_open[bidx];

    always_comb begin
        unique case (cfg_bl)
            2'd0:    bl_half = CNT_W'(1);
            2'd1:    bl_half = CNT_W'(2);
            default: bl_half = CNT_W'(BL_MAX / 2);
        endcase
        // windows are loaded as (spacing - 1): zero means legal
        ld_wr2pre = bl_half + CNT_W'(2);
        ld_rd2pre = bl_half - CNT_W'(1);
        ld_wr2rd  = bl_half + CNT_W'(1);
        ld_rd2wr  = bl_half + CNT_W'(1) + CNT_W'(cfg_cl25);
        ld_bst2wr = CNT_W'(1) + CNT_W'(cfg_cl25);
        ld_mrd    = CNT_W'(MRD_CYC - 1);
    end

    always_comb begin
        stall = 1'b0;
        viol  = 1'b0;
        unique case (cmd)
            CMD_ACT: begin
                if (mrs_busy)      stall = 1'b1;
                else if (sel_open) viol  = 1'b1;
            end
            CMD_MRS: stall = mrs_busy;
            CMD_RD: begin
                if (rdgate_busy)    stall = 1'b1;
                else if (!sel_open) viol  = 1'b1;
            end
            CMD_WR: begin
                if (wrgate_busy)    stall = 1'b1;
                else if (!sel_open) viol  = 1'b1;
            end
            CMD_PRE: stall = a10 ? (|slot_busy) : slot_busy[bidx];
            default: ;
        endcase
    end

    assign accept = (cmd != CMD_NOP) && (cmd != CMD_REF) && !stall && !viol;

    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic hit;
        assign hit = (bidx == 2'(i));
        ddr_bank_slot #(.W(CNT_W)) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (accept && cmd == CMD_ACT && hit),
            .close_i   (accept && cmd == CMD_PRE && (a10 || hit)),
            .col_i     (accept && (cmd == CMD_RD || cmd == CMD_WR) && hit),
            .col_ap_i  (a10),
            .col_val_i ((cmd == CMD_WR) ? ld_wr2pre : ld_rd2pre),
            .open_o    (slot_open[i]),
            .busy_o    (slot_busy[i])
        );
    end

    ddr_gap_timer #(.W(CNT_W)) i_rdgate (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept && cmd == CMD_WR),
        .replace_i (1'b0),
        .val_i     (ld_wr2rd),
        .busy_o    (rdgate_busy)
    );

    assign wrgate_load    = accept && (cmd == CMD_RD || cmd == CMD_BST);
    assign wrgate_replace = (cmd == CMD_BST);
    assign wrgate_val     = (cmd == CMD_BST) ? ld_bst2wr : ld_rd2wr;

    ddr_gap_timer #(.W(CNT_W)) i_wrgate (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (wrgate_load),
        .replace_i (wrgate_replace),
        .val_i     (wrgate_val),
        .busy_o    (wrgate_busy)
    );

    ddr_gap_timer #(.W(CNT_W)) i_mrsgate (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept && cmd == CMD_MRS),
        .replace_i (1'b1),
        .val_i     (ld_mrd),
        .busy_o    (mrs_busy)
    );

    assign bank_open = slot_open;

endmodule

// File: rtl/ddr_cmd_guard_chk.sv
module ddr_cmd_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [1:0] ba,
    input logic       a10,
    input logic       stall,
    input logic       viol,
    input logic [3:0] bank_open
);
    logic [2:0] rcw;
    logic [1:0] bix;
    logic is_act, is_rd, is_wr, is_pre, is_bst, is_mrs, ok;

    assign rcw    = {ras_n, cas_n, we_n};
    assign bix    = {ba[0], ba[1]};
    assign is_act = !cs_n && rcw == 3'b011;
    assign is_rd  = !cs_n && rcw == 3'b101;
    assign is_wr  = !cs_n && rcw == 3'b100;
    assign is_pre = !cs_n && rcw == 3'b010;
    assign is_bst = !cs_n && rcw == 3'b110;
    assign is_mrs = !cs_n && rcw == 3'b000;
    assign ok     = !stall && !viol;

    assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && ok) |=> bank_open[$past(bix)]);

    assert_pre_all_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && a10 && ok) |=> (bank_open == 4'b0000));

    assert_deselect_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!stall && !viol));

    assert_wr_holds_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && ok) |=> (!is_rd || stall));

    assert_bst_holds_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bst && ok) |=> (!is_wr || stall));

    assert_mrs_holds_act_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrs && ok) |=> (!is_act || stall));

endmodule

bind ddr_cmd_guard ddr_cmd_guard_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .a10       (a10),
    .stall     (stall),
    .viol      (viol),
    .bank_open (bank_open)
);

// File: tb/test_ddr_cmd_guard.sv
module test_ddr_cmd_guard;

    localparam logic [2:0] C_NOP = 3'b111;
    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_RD  = 3'b101;
    localparam logic [2:0] C_WR  = 3'b100;
    localparam logic [2:0] C_PRE = 3'b010;
    localparam logic [2:0] C_BST = 3'b110;
    localparam logic [2:0] C_MRS = 3'b000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'b00;
    logic a10 = 1'b0;
    logic [1:0] cfg_bl = 2'd1;
    logic cfg_cl25 = 1'b0;
    logic stall, viol;
    logic [3:0] bank_open;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    ddr_cmd_guard i_ddr_cmd_guard (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .cfg_bl(cfg_bl), .cfg_cl25(cfg_cl25),
        .stall(stall), .viol(viol), .bank_open(bank_open)
    );

    // driver: one command per cycle, expected result pushed to the scoreboard
    task automatic step(input logic cs, input logic [2:0] c, input logic [1:0] b,
                        input logic ap, input logic es, input logic ev,
                        input logic [3:0] eo, input string tag);
        @(negedge clk);
        cs_n = cs;
        {ras_n, cas_n, we_n} = c;
        ba  = b;
        a10 = ap;
        exp_q.push_back({es, ev, eo});
        tag_q.push_back(tag);
    endtask

    task automatic nop(input logic [3:0] eo, input string tag);
        step(1'b0, C_NOP, 2'b00, 1'b0, 1'b0, 1'b0, eo, tag);
    endtask

    // monitor: pops each expectation inside the cycle it belongs to
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() != 0) begin
                logic [5:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({stall, viol, bank_open} !== e) begin
                    fails++;
                    $display("FAIL %s: stall/viol/open actual %b/%b/%b expected %b/%b/%b",
                             t, stall, viol, bank_open, e[5], e[4], e[3:0]);
                end
            end
        end
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nop(4'b0000, "R1 reset idle");
        step(0, C_ACT, 2'b01, 0, 0, 0, 4'b0000, "R1 first cmd not stalled");
        nop(4'b0100, "R2 BA0 high maps to bank2");
        step(0, C_ACT, 2'b01, 0, 0, 1, 4'b0100, "R3 act to open bank");
        step(0, C_ACT, 2'b10, 0, 0, 0, 4'b0100, "R2 BA1 high maps to bank1");
        step(0, C_WR,  2'b10, 0, 0, 0, 4'b0110, "R8 write accepted");
        step(0, C_RD,  2'b01, 0, 1, 0, 4'b0110, "R8 read k=1");
        step(0, C_RD,  2'b01, 0, 1, 0, 4'b0110, "R8 read k=2");
        step(0, C_RD,  2'b01, 0, 1, 0, 4'b0110, "R8 read k=3");
        step(0, C_RD,  2'b01, 0, 0, 0, 4'b0110, "R8 read k=4 legal");
        step(0, C_PRE, 2'b10, 0, 0, 0, 4'b0110, "R7 pre after write k=5");
        step(0, C_WR,  2'b01, 0, 1, 0, 4'b0100, "R9 R4 write k=2, single pre");
        step(0, C_WR,  2'b01, 0, 1, 0, 4'b0100, "R9 write k=3");
        step(0, C_WR,  2'b01, 0, 0, 0, 4'b0100, "R9 write k=4 legal");
        step(0, C_PRE, 2'b01, 0, 1, 0, 4'b0100, "R7 pre k=1");
        step(0, C_PRE, 2'b00, 1, 1, 0, 4'b0100, "R13 stalled pre not applied");
        step(0, C_PRE, 2'b00, 1, 1, 0, 4'b0100, "R7 pre-all k=3");
        step(0, C_PRE, 2'b00, 1, 1, 0, 4'b0100, "R7 pre-all k=4");
        step(0, C_PRE, 2'b00, 1, 0, 0, 4'b0100, "R7 pre-all k=5 legal");
        nop(4'b0000, "R4 all closed");
        step(0, C_ACT, 2'b00, 0, 0, 0, 4'b0000, "R3 act bank0");
        nop(4'b0001, "R3 bank0 open");
        step(0, C_WR,  2'b11, 0, 0, 1, 4'b0001, "R5 write idle bank3");
        step(0, C_RD,  2'b00, 0, 0, 0, 4'b0001, "R5 rejected write loaded nothing");
        step(1, C_WR,  2'b00, 0, 0, 0, 4'b0001, "R6 deselected write");
        step(1, C_ACT, 2'b00, 0, 0, 0, 4'b0001, "R6 deselected act");
        step(1, C_PRE, 2'b00, 1, 0, 0, 4'b0001, "R6 deselected pre-all");
        step(0, C_WR,  2'b00, 1, 0, 0, 4'b0001, "R6 window ran while deselected");
        nop(4'b0001, "R12 ap k=1");
        nop(4'b0001, "R12 ap k=2");
        nop(4'b0001, "R12 ap k=3");
        nop(4'b0001, "R12 ap k=4");
        nop(4'b0000, "R12 ap closes at k=5");
        step(0, C_MRS, 2'b00, 0, 0, 0, 4'b0000, "R11 mrs");
        step(0, C_ACT, 2'b00, 0, 1, 0, 4'b0000, "R11 act k=1");
        step(0, C_ACT, 2'b00, 0, 0, 0, 4'b0000, "R11 act k=2 legal");
        nop(4'b0001, "R3 bank0 reopened");
        step(0, C_MRS, 2'b00, 0, 0, 0, 4'b0001, "R11 mrs");
        step(0, C_MRS, 2'b00, 0, 1, 0, 4'b0001, "R11 mrs k=1");
        step(0, C_MRS, 2'b00, 0, 0, 0, 4'b0001, "R11 mrs k=2 legal");
        cfg_cl25 = 1'b1;
        nop(4'b0001, "R13 cl 2.5 set");
        step(0, C_RD,  2'b00, 0, 0, 0, 4'b0001, "R9 read at cl2.5");
        step(0, C_BST, 2'b00, 0, 0, 0, 4'b0001, "R10 burst stop");
        step(0, C_WR,  2'b00, 0, 1, 0, 4'b0001, "R10 write k=1");
        step(0, C_WR,  2'b00, 0, 1, 0, 4'b0001, "R10 write k=2");
        step(0, C_WR,  2'b00, 0, 0, 0, 4'b0001, "R10 write k=3 overrides read window");
        nop(4'b0001, "R8 gap");
        nop(4'b0001, "R8 gap");
        nop(4'b0001, "R8 gap");
        step(0, C_RD,  2'b00, 0, 0, 0, 4'b0001, "R8 read k=4 legal");
        step(0, C_WR,  2'b00, 0, 1, 0, 4'b0001, "R9 cl2.5 write k=1");
        step(0, C_WR,  2'b00, 0, 1, 0, 4'b0001, "R9 cl2.5 write k=2");
        step(0, C_WR,  2'b00, 0, 1, 0, 4'b0001, "R9 cl2.5 write k=3");
        step(0, C_WR,  2'b00, 0, 1, 0, 4'b0001, "R9 cl2.5 write k=4");
        step(0, C_WR,  2'b00, 0, 0, 0, 4'b0001, "R9 cl2.5 write k=5 legal");
        cfg_bl = 2'd2;
        cfg_cl25 = 1'b0;
        nop(4'b0001, "R13 bl8 set");
        nop(4'b0001, "R7 gap");
        nop(4'b0001, "R7 gap");
        nop(4'b0001, "R7 gap");
        nop(4'b0001, "R7 gap");
        step(0, C_RD,  2'b00, 0, 0, 0, 4'b0001, "R7 read bl8");
        step(0, C_PRE, 2'b00, 0, 1, 0, 4'b0001, "R7 bl8 pre k=1");
        step(0, C_PRE, 2'b00, 0, 1, 0, 4'b0001, "R7 bl8 pre k=2");
        step(0, C_PRE, 2'b00, 0, 1, 0, 4'b0001, "R7 bl8 pre k=3");
        step(0, C_PRE, 2'b00, 0, 0, 0, 4'b0001, "R7 bl8 pre k=4 legal");
        nop(4'b0000, "R4 single pre closed bank0");
        step(0, C_ACT, 2'b00, 0, 0, 0, 4'b0000, "R3 act bank0");
        nop(4'b0001, "R3 bank0 open");
        step(0, C_MRS, 2'b00, 0, 0, 0, 4'b0001, "R11 mrs");
        step(0, C_ACT, 2'b00, 0, 1, 0, 4'b0001, "R13 stall beats viol");
        step(0, C_ACT, 2'b00, 0, 0, 1, 4'b0001, "R13 viol after window");
        nop(4'b0001, "R13 rejected act left state");
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule